// File: doc/BRIEF.md
# Dual-Mode Serial Receiver with Character Queue

This block turns an asynchronous serial line into characters and stores them, with per-character error flags, in a small first-in first-out queue that a host pops one entry at a time. Two sampling schemes are available. In oversampled mode a strobe arriving 16 times per bit period drives the receiver: it finds the falling start edge, confirms the start bit half a bit later, and then samples every following bit at its centre. In direct mode the receiver samples the line once on each rising edge of an external bit clock. The scheme is chosen by a control input and may be changed between characters.

The character format is set by inputs that select 7 or 8 data bits, parity on or off, parity sense, and one or two stop bits. The format and the sampling scheme are captured when a frame begins. A global enable and a receiver enable both gate reception. Dropping either of them returns the receiver to idle and empties the queue at once. Three mask inputs choose which queue conditions raise the interrupt request: full, at least half full, and at least one character waiting.

The receive sequencer has six states. ST_IDLE waits for a low line. On a 16x strobe it goes to ST_START, and on a bit-clock rise in direct mode it goes straight to ST_DATA. ST_START goes back to ST_IDLE on a glitch, or on to ST_DATA once the start bit is confirmed. ST_DATA goes to ST_PAR after the last data bit when parity is on, and to ST_STOP1 otherwise. ST_PAR goes to ST_STOP1. ST_STOP1 goes to ST_IDLE with a push for one stop bit, or to ST_STOP2 for two. ST_STOP2 goes to ST_IDLE with a push. A lost enable takes any state to ST_IDLE.

Top module: `rxq_uart`

## Requirements
- R1: After reset the queue is empty: rd_valid_o, full_o, half_o, overrun_o and irq_o are 0, level_o is 0 and rd_data_o is 0.
- R2: In 16x mode (mode_1x_i=0) a character made of a low start bit, data bits sent least significant bit first and a high stop bit, each lasting 16 strobes, is received and its byte appears at rd_data_o[7:0].
- R3: In 16x mode a low level that is no longer low at the eighth strobe after it was first seen is rejected, and no character is queued.
- R4: In direct mode (mode_1x_i=1) each bit is taken on the rising edge of bitclk_i, and the character is received just as in R2.
- R5: The sampling mode and the format inputs are captured at the start of each frame, so consecutive characters may use different modes.
- R6: With eight_bit_i=0 seven data bits are received, and rd_data_o[7] reads 0.
- R7: With par_en_i=1 a parity bit follows the data. When the data bits plus the parity bit hold an odd count of ones and par_odd_i=0, or an even count and par_odd_i=1, the entry's parity-error flag rd_data_o[9] is 1; otherwise it is 0. With par_en_i=0 no parity bit is expected and the flag is 0.
- R8: With two_stop_i=1 two stop bits are expected. The framing-error flag rd_data_o[8] is 1 when any expected stop bit is sampled low.
- R9: The queue holds DEPTH (8) entries in arrival order. rd_data_o shows the oldest entry while rd_valid_o is 1, and rd_i pops it. A pop of an empty queue changes nothing, and rd_data_o is 0 while the queue is empty.
- R10: full_o is 1 exactly when level_o equals DEPTH. half_o is 1 exactly when level_o is at least DEPTH/2.
- R11: A character that arrives while the queue is full is dropped and sets overrun_o. The flag stays set until a pop or a disable clears it.
- R12: While rx_en_i is 0 the receiver is idle, nothing is queued, and the queue and overrun_o are cleared on the next clock edge.
- R13: While blk_en_i is 0 the whole block is inactive, in the same way as in R12.
- R14: irq_o is 1 when full_o is 1 with ie_full_i set, or half_o is 1 with ie_half_i set, or rd_valid_o is 1 with ie_ready_i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial receive line, idles high |
| tick16_i | input | 1 | Strobe at 16 times the bit rate, one clock wide |
| bitclk_i | input | 1 | Bit clock for direct mode, sampled as a level |
| blk_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receiver enable |
| mode_1x_i | input | 1 | 0 = 16x centre sampling, 1 = sampling on bit-clock rise |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| two_stop_i | input | 1 | 0 = one stop bit, 1 = two stop bits |
| eight_bit_i | input | 1 | 0 = seven data bits, 1 = eight |
| ie_full_i | input | 1 | Interrupt mask for queue full |
| ie_half_i | input | 1 | Interrupt mask for queue half full |
| ie_ready_i | input | 1 | Interrupt mask for character waiting |
| rd_i | input | 1 | Pop the oldest entry |
| rd_data_o | output | 10 | {parity error, framing error, data byte} of the oldest entry |
| rd_valid_o | output | 1 | At least one entry is waiting |
| level_o | output | 4 | Number of entries held |
| full_o | output | 1 | Queue full |
| half_o | output | 1 | Queue at least half full |
| overrun_o | output | 1 | Sticky flag for a dropped character |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A character enters the queue on the clock edge that follows the sample of its final stop bit. That sample comes two synchroniser stages after the line settles, plus up to one strobe period, so the bench does not wait for a fixed cycle: it checks the queue only after the whole frame and one further idle bit have been driven. Level, flag and interrupt outputs change on the edge after a push, pop or disable. The bench therefore drives inputs on the falling clock edge and checks at the next falling edge, after a single rising edge has passed. Errors are forced by corrupting the parity bit or holding a stop bit low.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rxq_word_t;

    typedef struct packed {
        logic x1;
        logic eight;
        logic par_en;
        logic odd;
        logic two_stop;
    } rxq_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rxq_state_e;

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic bclk_i,
    output logic line_s_o,
    output logic bclk_rise_o
);
    logic [STAGES-1:0] line_sr;
    logic [STAGES:0]   bclk_sr;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    line_sr[0] <= 1'b1;
                    bclk_sr[0] <= 1'b0;
                end else begin
                    line_sr[0] <= line_i;
                    bclk_sr[0] <= bclk_i;
                end
            end
        end else if (g < STAGES) begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    line_sr[g] <= 1'b1;
                    bclk_sr[g] <= 1'b0;
                end else begin
                    line_sr[g] <= line_sr[g-1];
                    bclk_sr[g] <= bclk_sr[g-1];
                end
            end
        end else begin : g_edge
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bclk_sr[g] <= 1'b0;
                else        bclk_sr[g] <= bclk_sr[g-1];
            end
        end
    end

    assign line_s_o    = line_sr[STAGES-1];
    assign bclk_rise_o = bclk_sr[STAGES-1] & ~bclk_sr[STAGES];
endmodule

// File: rtl/rxq_frame.sv
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active_i,
    input  logic      line_i,
    input  logic      tick_i,
    input  logic      rise_i,
    input  rxq_fmt_t  fmt_i,
    output logic      push_o,
    output rxq_word_t word_o
);
    localparam int CNTW = $clog2(OSR);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(OSR - 1);
    localparam logic [CNTW-1:0] CNT_MID  = CNTW'(OSR / 2 - 1);

    rxq_state_e     st_q, st_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [2:0]     nb_q, nb_d;
    logic [7:0]     sh_q, sh_d;
    logic           acc_q, acc_d;
    logic           perr_q, perr_d;
    logic           ferr_q, ferr_d;
    rxq_fmt_t       fmt_q, fmt_d;

    logic       samp;
    logic [2:0] last_bit;
    logic       in_frame;

    assign samp     = fmt_q.x1 ? rise_i : (tick_i && (cnt_q == CNT_LAST));
    assign last_bit = fmt_q.eight ? 3'd7 : 3'd6;
    assign in_frame = (st_q == ST_DATA) || (st_q == ST_PAR) ||
                      (st_q == ST_STOP1) || (st_q == ST_STOP2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            nb_q   <= '0;
            sh_q   <= '0;
            acc_q  <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            fmt_q  <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            nb_q   <= nb_d;
            sh_q   <= sh_d;
            acc_q  <= acc_d;
            perr_q <= perr_d;
            ferr_q <= ferr_d;
            fmt_q  <= fmt_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        nb_d   = nb_q;
        sh_d   = sh_q;
        acc_d  = acc_q;
        perr_d = perr_q;
        ferr_d = ferr_q;
        fmt_d  = fmt_q;
        if (in_frame && tick_i) cnt_d = cnt_q + 1'b1;
        if (!active_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    cnt_d  = '0;
                    nb_d   = '0;
                    acc_d  = 1'b0;
                    perr_d = 1'b0;
                    ferr_d = 1'b0;
                    fmt_d  = fmt_i;
                    if (!fmt_i.x1 && tick_i && !line_i)
                        st_d = ST_START;
                    else if (fmt_i.x1 && rise_i && !line_i)
                        st_d = ST_DATA;
                end
                ST_START: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_MID) begin
                            cnt_d = '0;
                            st_d  = line_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (samp) begin
                        sh_d  = {line_i, sh_q[7:1]};
                        acc_d = acc_q ^ line_i;
                        nb_d  = nb_q + 1'b1;
                        if (nb_q == last_bit)
                            st_d = fmt_q.par_en ? ST_PAR : ST_STOP1;
                    end
                end
                ST_PAR: begin
                    if (samp) begin
                        perr_d = acc_q ^ line_i ^ fmt_q.odd;
                        st_d   = ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (samp) begin
                        ferr_d = ~line_i;
                        st_d   = fmt_q.two_stop ? ST_STOP2 : ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    if (samp) begin
                        ferr_d = ferr_q | ~line_i;
                        st_d   = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        push_o      = 1'b0;
        word_o.perr = perr_q;
        word_o.ferr = ferr_q;
        word_o.data = fmt_q.eight ? sh_q : {1'b0, sh_q[7:1]};
        if (active_i && samp) begin
            unique case (st_q)
                ST_STOP1: begin
                    push_o      = ~fmt_q.two_stop;
                    word_o.ferr = ~line_i;
                end
                ST_STOP2: begin
                    push_o      = 1'b1;
                    word_o.ferr = ferr_q | ~line_i;
                end
                default: push_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  rxq_word_t                  word_i,
    input  logic                       pop_i,
    output rxq_word_t                  word_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       ovr_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

    rxq_word_t       mem [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic [CW-1:0]   cnt_q;
    logic            ovr_q;
    logic            full, empty, do_push, do_pop;

    assign full    = (cnt_q == LVL_FULL);
    assign empty   = (cnt_q == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty;

    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem[wptr_q] <= word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
        end else if (flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push_i && full) ovr_q <= 1'b1;
            else if (do_pop)    ovr_q <= 1'b0;
        end
    end

    assign word_o  = empty ? '0 : mem[rptr_q];
    assign level_o = cnt_q;
    assign ovr_o   = ovr_q;
endmodule

// File: rtl/rxq_uart.sv
module rxq_uart
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int OSR    = 16,
    parameter int STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       line_i,
    input  logic                       tick16_i,
    input  logic                       bitclk_i,
    input  logic                       blk_en_i,
    input  logic                       rx_en_i,
    input  logic                       mode_1x_i,
    input  logic                       par_en_i,
    input  logic                       par_odd_i,
    input  logic                       two_stop_i,
    input  logic                       eight_bit_i,
    input  logic                       ie_full_i,
    input  logic                       ie_half_i,
    input  logic                       ie_ready_i,
    input  logic                       rd_i,
    output logic [9:0]                 rd_data_o,
    output logic                       rd_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       full_o,
    output logic                       half_o,
    output logic                       overrun_o,
    output logic                       irq_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

    logic      active, line_s, rise, push;
    rxq_fmt_t  fmt;
    rxq_word_t word_in, word_out;
    logic [CW-1:0] level;

    assign active = blk_en_i & rx_en_i;
    assign fmt    = '{x1: mode_1x_i, eight: eight_bit_i, par_en: par_en_i,
                      odd: par_odd_i, two_stop: two_stop_i};

    rxq_sync #(.STAGES(STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .bclk_i      (bitclk_i),
        .line_s_o    (line_s),
        .bclk_rise_o (rise)
    );

    rxq_frame #(.OSR(OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .line_i   (line_s),
        .tick_i   (tick16_i),
        .rise_i   (rise),
        .fmt_i    (fmt),
        .push_o   (push),
        .word_o   (word_in)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (~active),
        .push_i  (push),
        .word_i  (word_in),
        .pop_i   (rd_i),
        .word_o  (word_out),
        .level_o (level),
        .ovr_o   (overrun_o)
    );

    assign rd_data_o  = word_out;
    assign level_o    = level;
    assign rd_valid_o = (level != '0);
    assign full_o     = (level == LVL_FULL);
    assign half_o     = (level >= LVL_HALF);
    assign irq_o      = (full_o & ie_full_i) | (half_o & ie_half_i) |
                        (rd_valid_o & ie_ready_i);
endmodule

// File: rtl/rxq_uart_chk.sv
module rxq_uart_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       blk_en_i,
    input logic                       rx_en_i,
    input logic                       rd_i,
    input logic                       rd_valid_o,
    input logic [$clog2(DEPTH+1)-1:0] level_o,
    input logic                       full_o,
    input logic                       half_o,
    input logic                       overrun_o,
    input logic                       irq_o
);
    p_full_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (half_o && rd_valid_o));

    p_level_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= ($clog2(DEPTH+1))'(DEPTH));

    p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rd_valid_o && rx_en_i && blk_en_i) |=> (level_o <= $past(level_o)));

    p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> (!rd_valid_o && !overrun_o));

    p_sleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en_i |=> (level_o == '0));

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !rd_i && rx_en_i && blk_en_i) |=> overrun_o);

    p_irq_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> !irq_o);
endmodule

bind rxq_uart rxq_uart_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_en_i   (blk_en_i),
    .rx_en_i    (rx_en_i),
    .rd_i       (rd_i),
    .rd_valid_o (rd_valid_o),
    .level_o    (level_o),
    .full_o     (full_o),
    .half_o     (half_o),
    .overrun_o  (overrun_o),
    .irq_o      (irq_o)
);

// File: tb/test_rxq_uart.sv
module test_rxq_uart;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1, tick = 1'b0, bclk = 1'b0;
    logic blk_en = 1'b0, rx_en = 1'b0, x1 = 1'b0, pen = 1'b0, odd = 1'b0;
    logic two = 1'b0, eight = 1'b0, ief = 1'b0, ieh = 1'b0, ier = 1'b0, rd = 1'b0;
    logic [9:0] rdata;
    logic       valid, full, half, ovr, irq;
    logic [3:0] level;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxq_uart i_rxq_uart (
        .clk(clk), .rst_n(rst_n), .line_i(line), .tick16_i(tick), .bitclk_i(bclk),
        .blk_en_i(blk_en), .rx_en_i(rx_en), .mode_1x_i(x1), .par_en_i(pen),
        .par_odd_i(odd), .two_stop_i(two), .eight_bit_i(eight),
        .ie_full_i(ief), .ie_half_i(ieh), .ie_ready_i(ier), .rd_i(rd),
        .rd_data_o(rdata), .rd_valid_o(valid), .level_o(level), .full_o(full),
        .half_o(half), .overrun_o(ovr), .irq_o(irq)
    );

    // 16x strobe: one clock in four
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick = (div == 0);
            div  = (div + 1) % 4;
        end
    end

    // fields: x1 eight pen odd two badp bads data[8] expdata[8] expperr expferr
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD3, 8'h53, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC7, 8'hC7, 1'b0, 1'b1}
    };
    localparam string VTAG [8] = '{"R2", "R4 R5", "R6", "R6 R7", "R7", "R8", "R8", "R8"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic m1x, input logic b, input logic short_low);
        line = b;
        if (m1x) begin
            bclk = 1'b0;
            repeat (8) @(negedge clk);
            bclk = 1'b1;
            repeat (8) @(negedge clk);
        end else if (short_low) begin
            repeat (48) @(negedge clk);
            line = 1'b1;
            repeat (16) @(negedge clk);
        end else begin
            repeat (64) @(negedge clk);
        end
    endtask

    task automatic send(input logic m1x, input logic e8, input logic pe, input logic po,
                        input logic ts, input logic badp, input logic bads,
                        input logic [7:0] d);
        logic [7:0] dd;
        x1 = m1x; eight = e8; pen = pe; odd = po; two = ts;
        dd = e8 ? d : {1'b0, d[6:0]};
        put_bit(m1x, 1'b0, 1'b0);
        for (int i = 0; i < (e8 ? 8 : 7); i++) put_bit(m1x, d[i], 1'b0);
        if (pe) put_bit(m1x, (^dd) ^ po ^ badp, 1'b0);
        put_bit(m1x, ~bads, bads);
        if (ts) put_bit(m1x, 1'b1, 1'b0);
        put_bit(m1x, 1'b1, 1'b0);
        if (!m1x) repeat (64) @(negedge clk);
    endtask

    task automatic pop();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", valid, 0);
        chk("R1 level", level, 0);
        chk("R1 flags", {full, half, ovr, irq}, 0);
        chk("R1 data", rdata, 0);

        blk_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < 8; v++) begin
            logic [24:0] e;
            e = VEC[v];
            send(e[24], e[23], e[22], e[21], e[20], e[19], e[18], e[17:10]);
            chk({VTAG[v], " R9 valid"}, valid, 1);
            chk({VTAG[v], " word"}, {rdata[9], rdata[8], rdata[7:0]}, {e[1], e[0], e[9:2]});
            pop();
            chk("R9 drained", level, 0);
        end

        // R3 glitch rejection, then recovery
        x1 = 1'b0; line = 1'b0;
        repeat (16) @(negedge clk);
        line = 1'b1;
        repeat (400) @(negedge clk);
        chk("R3 glitch dropped", level, 0);
        send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96);
        chk("R3 recovery", rdata, 10'h096);
        pop();

        // R9 pop of empty queue
        pop();
        chk("R9 empty pop level", level, 0);
        chk("R9 empty data", rdata, 0);

        // fill, half, full, overrun
        ief = 1'b1;
        for (int k = 0; k < 8; k++) begin
            send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'(k * 17 + 1));
            if (k == 2) chk("R10 half at 3", half, 0);
            if (k == 3) begin
                chk("R10 half at 4", half, 1);
                chk("R14 half masked", irq, 0);
            end
            if (k == 6) chk("R10 full at 7", full, 0);
        end
        chk("R10 full at 8", full, 1);
        chk("R9 level 8", level, 8);
        chk("R14 full irq", irq, 1);
        ief = 1'b0; ieh = 1'b1;
        @(negedge clk);
        chk("R14 half irq", irq, 1);
        ieh = 1'b0;
        @(negedge clk);
        chk("R14 all masked", irq, 0);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hEE);
        chk("R11 overrun set", ovr, 1);
        chk("R11 level kept", level, 8);
        repeat (20) @(negedge clk);
        chk("R11 sticky", ovr, 1);
        for (int k = 0; k < 8; k++) begin
            chk("R9 order", rdata, 10'(k * 17 + 1));
            pop();
            if (k == 0) chk("R11 cleared by pop", ovr, 0);
        end
        chk("R11 dropped char absent", valid, 0);

        // R12 flush on receiver disable
        ier = 1'b1;
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22);
        chk("R14 ready irq", irq, 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R12 flushed", {valid, level}, 0);
        chk("R12 irq low", irq, 0);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h33);
        chk("R12 no receive", level, 0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R12 stays empty", level, 0);

        // R13 global disable
        send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44);
        chk("R13 enabled receive", rdata, 10'h044);
        blk_en = 1'b0;
        @(negedge clk);
        chk("R13 flushed", level, 0);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55);
        chk("R13 no receive", level, 0);
        blk_en = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule